// File: doc/BRIEF.md
# Erasable PROM with programming-mode front end

This block is a synthesizable behavioural model of a byte-wide erasable PROM together with the logic that runs it in both of its modes. With the mode-enable input low, it is an ordinary read-only memory. An active-low chip select asks for the addressed byte, which appears on the data output with an output-enable flag one clock later. When the chip select is released, the output enable drops. In the power-switched build, a standby flag also rises.

With the mode-enable input high, the pins take on new roles. A latch strobe captures the lowest address lines into an internal register, and that register supplies the upper address bits. The low eight address bits come straight from the pins. Two active-low strobes select program, verify (also used for blank check) or inhibit. Driving both strobes low is flagged as illegal and writes nothing. A program operation can only clear bits, because the stored word becomes the old word ANDed with the input byte.

Erasure is modelled by a sweep that rewrites every word to all ones, one word per clock. Reset or the erase input starts the sweep. The address width is a parameter: 13 bits gives the full 8192 x 8 array, and the default of 11 bits keeps elaboration small.

Top module: `eprom_mode_ctrl`

## Requirements
- R1: With prog_en low and csel_n low, the next clock edge sets dout_oe to 1, and dout then shows the word at addr.
- R2: With prog_en low and csel_n high, the next clock edge sets dout_oe to 0, and dout reads 0.
- R3: When POWER_SWITCHED is 1, standby is 1 after an edge that samples read mode with csel_n high, and 0 after any other sampled state, including every programming-mode state.
- R4: While prog_en is high, stb_latch high captures addr[AW-9:0] into the upper address register, which supplies address bits [AW-1:8]. Bits [7:0] come from addr directly. The register resets to 0 and holds its value while not strobed.
- R5: Program mode is prog_en=1, prog_n=0, vrfy_n=1. Held for two or more clocks at a stable address with din stable, it stores (old word AND din). A one-clock pulse changes nothing, and dout_oe stays 0 throughout.
- R6: Verify mode is prog_en=1, prog_n=1, vrfy_n=0. It sets dout_oe to 1 and drives the addressed word on dout. For blank check, an erased word reads 0xFF.
- R7: Inhibit mode is prog_en=1 with both prog_n and vrfy_n high. It leaves dout_oe at 0.
- R8: prog_en=1 with prog_n=0 and vrfy_n=0 sets illegal to 1 on the next edge and holds dout_oe at 0. No word is written.
- R9: Reset or a one-clock erase pulse rewrites every word to 0xFF within 2^AW clocks. Program pulses during that sweep are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts the erase sweep |
| prog_en | input | 1 | 1 selects programming-mode decoding, 0 selects read mode |
| addr | input | AW | Address pins; low bits also carry upper-address values for the latch |
| csel_n | input | 1 | Active-low chip select (read mode) |
| stb_latch | input | 1 | Upper-address latch strobe (programming mode) |
| prog_n | input | 1 | Active-low program strobe |
| vrfy_n | input | 1 | Active-low verify strobe |
| din | input | DW | Data to program |
| erase | input | 1 | One-clock pulse starts the erase sweep |
| dout | output | DW | Read or verify data, 0 when not driven |
| dout_oe | output | 1 | Output driver enable; 0 stands for high impedance |
| illegal | output | 1 | Both strobes were low in programming mode |
| standby | output | 1 | Low-power standby indicator |

## Verification
On every cycle, the assertions check how the strobes and chip select map to output enable, the illegal flag and standby. They also check that the upper-address register changes only under its strobe, and that a write happens only after a cycle of legal program mode. Only the bench scenarios can show what the array holds. That covers the AND-only update across repeated programming, the discarded one-clock and illegal pulses, blank words reading 0xFF after the sweep, and words reached through a latched upper address reading back at the matching full address in read mode.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  typedef enum logic [2:0] {
    OP_READ,
    OP_DESEL,
    OP_PROG,
    OP_VERIFY,
    OP_INHIBIT,
    OP_ILLEGAL
  } eprom_op_e;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic      prog_en,
  input  logic      csel_n,
  input  logic      prog_n,
  input  logic      vrfy_n,
  output eprom_op_e op
);
  always_comb begin
    if (!prog_en) begin
      op = csel_n ? OP_DESEL : OP_READ;
    end else begin
      unique case ({prog_n, vrfy_n})
        2'b01:   op = OP_PROG;
        2'b10:   op = OP_VERIFY;
        2'b11:   op = OP_INHIBIT;
        default: op = OP_ILLEGAL;
      endcase
    end
  end
endmodule

// File: rtl/eprom_hi_latch.sv
module eprom_hi_latch #(
  parameter int HI_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prog_en,
  input  logic            stb_latch,
  input  logic [HI_W-1:0] low_lines,
  output logic [HI_W-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (rst) hi_q <= '0;
    else if (prog_en && stb_latch) hi_q <= low_lines;
  end
endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          erase,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          sweeping
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] sw_cnt;

  always_ff @(posedge clk) begin
    if (rst || erase) begin
      sweeping <= 1'b1;
      sw_cnt   <= '0;
    end else if (sweeping) begin
      if (sw_cnt == LAST) sweeping <= 1'b0;
      sw_cnt <= sw_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (sweeping) mem[sw_cnt] <= '1;
    else if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/eprom_mode_ctrl.sv
module eprom_mode_ctrl
  import eprom_pkg::*;
#(
  parameter int AW             = 11,
  parameter int DW             = 8,
  parameter bit POWER_SWITCHED = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_en,
  input  logic [AW-1:0] addr,
  input  logic          csel_n,
  input  logic          stb_latch,
  input  logic          prog_n,
  input  logic          vrfy_n,
  input  logic [DW-1:0] din,
  input  logic          erase,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          illegal,
  output logic          standby
);
  localparam int LO_W = 8;
  localparam int HI_W = AW - LO_W;

  eprom_op_e     op;
  logic [HI_W-1:0] hi_q;
  logic [AW-1:0] eff_addr, ea_q;
  logic [DW-1:0] rd_data;
  logic          sweeping, pg_q, wr_en;
  logic          oe_q, ill_q, sb_q;

  eprom_mode_dec dec_i (
    .prog_en(prog_en), .csel_n(csel_n), .prog_n(prog_n), .vrfy_n(vrfy_n), .op(op)
  );

  eprom_hi_latch #(.HI_W(HI_W)) latch_i (
    .clk(clk), .rst(rst), .prog_en(prog_en), .stb_latch(stb_latch),
    .low_lines(addr[HI_W-1:0]), .hi_q(hi_q)
  );

  assign eff_addr = prog_en ? {hi_q, addr[LO_W-1:0]} : addr;

  // Read-modify-write: the word read on the previous edge is ANDed with din.
  assign wr_en = (op == OP_PROG) && pg_q && (eff_addr == ea_q) && !sweeping;

  eprom_array #(.AW(AW), .DW(DW)) array_i (
    .clk(clk), .rst(rst), .erase(erase), .rd_addr(eff_addr),
    .wr_en(wr_en), .wr_addr(eff_addr), .wr_data(rd_data & din),
    .rd_data(rd_data), .sweeping(sweeping)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_q  <= 1'b0;
      ea_q  <= '0;
      oe_q  <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      pg_q  <= (op == OP_PROG) && !sweeping;
      ea_q  <= eff_addr;
      oe_q  <= (op == OP_READ) || (op == OP_VERIFY);
      ill_q <= (op == OP_ILLEGAL);
    end
  end

  generate
    if (POWER_SWITCHED) begin : g_pwr
      always_ff @(posedge clk) begin
        if (rst) sb_q <= 1'b0;
        else     sb_q <= (op == OP_DESEL);
      end
    end else begin : g_nopwr
      assign sb_q = 1'b0;
    end
  endgenerate

  assign dout    = oe_q ? rd_data : '0;
  assign dout_oe = oe_q;
  assign illegal = ill_q;
  assign standby = sb_q;
endmodule

// File: rtl/eprom_mode_chk.sv
module eprom_mode_chk #(
  parameter int HI_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            prog_en,
  input logic            csel_n,
  input logic            stb_latch,
  input logic            prog_n,
  input logic            vrfy_n,
  input logic            dout_oe,
  input logic            illegal,
  input logic            standby,
  input logic [HI_W-1:0] hi_q,
  input logic            wr_en
);
  AST_DESEL_OFF: assert property (@(posedge clk) disable iff (rst)
    (!prog_en && csel_n) |=> !dout_oe); // R2
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
    standby |-> !dout_oe); // R3
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(prog_en && stb_latch) |=> $stable(hi_q)); // R4
  AST_WRITE_AFTER_PROG: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(prog_en) && !$past(prog_n) && $past(vrfy_n))); // R5
  AST_VERIFY_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (prog_en && prog_n && !vrfy_n) |=> dout_oe); // R6
  AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (rst)
    (prog_en && prog_n && vrfy_n) |=> !dout_oe); // R7
  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (prog_en && !prog_n && !vrfy_n) |=> (illegal && !dout_oe)); // R8
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (prog_en && !prog_n && !vrfy_n) |-> !wr_en); // R8
endmodule

bind eprom_mode_ctrl eprom_mode_chk #(.HI_W(HI_W)) chk_i (
  .clk(clk), .rst(rst), .prog_en(prog_en), .csel_n(csel_n),
  .stb_latch(stb_latch), .prog_n(prog_n), .vrfy_n(vrfy_n),
  .dout_oe(dout_oe), .illegal(illegal), .standby(standby),
  .hi_q(hi_q), .wr_en(wr_en)
);

// File: tb/eprom_mode_ctrl_tb_top.sv
module eprom_mode_ctrl_tb_top;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NV = 12;
  // vector: {op[1:0], addr[10:0], value[7:0]}; op 0=program, 1=verify, 2=read
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 11'h123, 8'hA5}, {2'd1, 11'h123, 8'hA5},
    {2'd0, 11'h123, 8'h3C}, {2'd1, 11'h123, 8'h24},
    {2'd0, 11'h7FF, 8'h00}, {2'd1, 11'h7FF, 8'h00},
    {2'd2, 11'h123, 8'h24}, {2'd2, 11'h000, 8'hFF},
    {2'd1, 11'h456, 8'hFF}, {2'd0, 11'h005, 8'hF0},
    {2'd2, 11'h005, 8'hF0}, {2'd2, 11'h7FF, 8'h00}
  };

  logic clk = 1'b0, rst = 1'b1, prog_en = 1'b0, csel_n = 1'b1;
  logic stb_latch = 1'b0, prog_n = 1'b1, vrfy_n = 1'b1, erase = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_oe, illegal, standby;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eprom_mode_ctrl #(.AW(AW), .DW(DW), .POWER_SWITCHED(1'b1)) dut_i (
    .clk(clk), .rst(rst), .prog_en(prog_en), .addr(addr), .csel_n(csel_n),
    .stb_latch(stb_latch), .prog_n(prog_n), .vrfy_n(vrfy_n), .din(din),
    .erase(erase), .dout(dout), .dout_oe(dout_oe), .illegal(illegal),
    .standby(standby)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic latch_hi(input logic [AW-1:0] a);
    prog_en = 1'b1; prog_n = 1'b1; vrfy_n = 1'b1;
    addr = AW'(a[AW-1:8]); stb_latch = 1'b1;
    @(negedge clk);
    stb_latch = 1'b0; addr = a;
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [DW-1:0] d, input int cycles);
    latch_hi(a);
    din = d; prog_n = 1'b0;
    repeat (cycles) @(negedge clk);
    check("R5 oe during program", dout_oe, 0);
    prog_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_verify(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
    latch_hi(a);
    vrfy_n = 1'b0;
    @(negedge clk);
    check({req, " oe"}, dout_oe, 1);
    check({req, " data"}, dout, e);
    vrfy_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
    prog_en = 1'b0; addr = a; csel_n = 1'b0;
    @(negedge clk);
    check({req, " oe"}, dout_oe, 1);
    check({req, " data"}, dout, e);
    csel_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("reset oe", dout_oe, 0);
    check("reset illegal", illegal, 0);
    check("reset standby", standby, 0);
    rst = 1'b0;
    repeat (DEPTH + 4) @(negedge clk);
    check("R2 deselect oe", dout_oe, 0);
    check("R2 deselect dout", dout, 0);
    check("R3 standby deselected", standby, 1);
    // R4: latch resets to zero, low bits from pins
    prog_en = 1'b1; addr = 11'h010; vrfy_n = 1'b0;
    @(negedge clk);
    check("R4 reset latch verify", dout, 8'hFF);
    check("R3 standby in programming mode", standby, 0);
    vrfy_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][20:19])
        2'd0: do_prog(VEC[i][18:8], VEC[i][7:0], 3);
        2'd1: do_verify(VEC[i][18:8], VEC[i][7:0], "R6 R5 R4 verify vector");
        default: do_read(VEC[i][18:8], VEC[i][7:0], "R1 R4 read vector");
      endcase
    end

    // R7 inhibit
    latch_hi(11'h123);
    @(negedge clk);
    check("R7 inhibit oe", dout_oe, 0);
    // R8 illegal: both strobes low, no write
    din = 8'h00; prog_n = 1'b0; vrfy_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 illegal flag", illegal, 1);
    check("R8 illegal oe", dout_oe, 0);
    prog_n = 1'b1; vrfy_n = 1'b1;
    @(negedge clk);
    check("R8 illegal cleared", illegal, 0);
    do_verify(11'h123, 8'h24, "R8 no write");
    // R5 one-clock pulse writes nothing
    do_prog(11'h456, 8'h00, 1);
    do_verify(11'h456, 8'hFF, "R5 short pulse");
    // R9 erase sweep
    prog_en = 1'b0;
    erase = 1'b1;
    @(negedge clk);
    erase = 1'b0;
    repeat (DEPTH + 4) @(negedge clk);
    do_read(11'h123, 8'hFF, "R9 erased");
    do_read(11'h7FF, 8'hFF, "R9 erased top");
    do_read(11'h005, 8'hFF, "R9 erased low");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule